// File: doc/BRIEF.md
# Gate driver fault supervisor

This block watches the health of a half-bridge gate driver and holds a latched fault. Five conditions can raise it. Two are undervoltage flags, one for the low-side supply and one for the floating supply. Two are the overcurrent trip flags of the lower and upper switch. The fifth is a disagreement between the sensed output phase and a commanded-on upper switch. Each condition must persist for a set number of clock cycles before it counts, so short glitches are rejected.

Once raised, the fault stays set after its cause has gone. It is cleared only by holding the enable command low for a minimum number of consecutive cycles. A cause that is still present keeps the fault set through any clear attempt. The block drives an active-low, open-drain-style fault line for the board. It also drives a fault-active level that the gate sequencer uses to remove both drives.

The phase check is armed only after the upper switch has been commanded on for a turn-on delay, so normal switching edges do not trip it. After reset the fault is active until the first valid clear.

Top module: `gd_fault_sup`

## Requirements
- R1: While rst_ni is low, and after its release until the first clear, fault_o is 1 and fault_no is 0.
- R2: With no condition present, enable_i sampled low on CLR_CYC consecutive rising edges clears the fault on the next edge: fault_o becomes 0 and fault_no becomes 1.
- R3: enable_i low for fewer than CLR_CYC consecutive edges does not clear the fault.
- R4: trip_lo_i sampled high on TRIP_FILT consecutive edges sets the fault on the next edge, whatever the value of upper_cmd_i. The fault is not set after only TRIP_FILT edges.
- R5: trip_hi_i sampled high on TRIP_FILT consecutive edges sets the fault on the next edge while the upper switch is commanded on.
- R6: A trip pulse lasting fewer than TRIP_FILT edges does not set the fault.
- R7: uv_low_i or uv_float_i sampled high on UV_FILT consecutive edges sets the fault. While the flag stays high, enable_i held low for longer than CLR_CYC edges does not clear it. Once the flag falls with enable_i still low, the fault clears on the second edge after that.
- R8: upper_cmd_i high (1 = upper on) for ARM_DLY edges arms the phase check. After that, phase_hi_i low (0 = output node low) for PHASE_FILT further edges sets the fault on the next edge.
- R9: phase_hi_i low while upper_cmd_i is 0, or only during the ARM_DLY window after the upper command rises, does not set the fault.
- R10: Once set, the fault stays set after every condition has been removed, until a clear per R2.
- R11: fault_no is always the complement of fault_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Enable command; held low to clear the fault |
| upper_cmd_i | input | 1 | Commanded upper switch state, 1 = on |
| phase_hi_i | input | 1 | Phase sense, 1 = output node high |
| uv_low_i | input | 1 | Low-side supply undervoltage flag |
| uv_float_i | input | 1 | Floating supply undervoltage flag |
| trip_lo_i | input | 1 | Lower switch overcurrent trip |
| trip_hi_i | input | 1 | Upper switch overcurrent trip |
| fault_no | output | 1 | Latched fault, active low |
| fault_o | output | 1 | Latched fault, active high, to the gate sequencer |

## Verification
The assertions check four rules on every cycle. A filtered condition always leads to the fault on the next cycle. The fault falls only after enable has been low. The fault rises only when a filtered condition was present. The phase check stays quiet while the upper switch is commanded off. Only the bench scenarios can show the exact cycle counts. These are the glitch-filter length, the arming delay, and the clear window one cycle short of the limit. The scenarios also cover undervoltage blocking a long clear and the release that follows once the flag falls.

// File: rtl/gd_fault_pkg.sv
package gd_fault_pkg;
  localparam int unsigned NUM_SRC = 4;

  // index of each filtered fault source in src_q
  typedef enum logic [1:0] {
    SRC_UV_LO   = 2'd0,
    SRC_UV_FL   = 2'd1,
    SRC_TRIP_LO = 2'd2,
    SRC_TRIP_HI = 2'd3
  } src_idx_e;
endpackage

// File: rtl/gd_persist.sv
// q_o rises after in_i has been sampled high on N consecutive edges
module gd_persist #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(N) + 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (!in_i) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else begin
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      q_o <= (cnt_q == LAST);
    end
  end
endmodule

// File: rtl/gd_phase_chk.sv
// flags phase low while upper is commanded on, after the arming delay
module gd_phase_chk #(
  parameter int unsigned ARM_DLY    = 8,
  parameter int unsigned PHASE_FILT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upper_cmd_i,
  input  logic phase_hi_i,
  output logic mismatch_o
);
  logic armed;
  logic raw_mis;

  gd_persist #(.N(ARM_DLY)) u_arm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (upper_cmd_i),
    .q_o   (armed)
  );

  assign raw_mis = armed & upper_cmd_i & ~phase_hi_i;

  gd_persist #(.N(PHASE_FILT)) u_mis (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (raw_mis),
    .q_o   (mismatch_o)
  );
endmodule

// File: rtl/gd_clr_timer.sv
// clr_ok_o high once enable has been sampled low on CLR_CYC consecutive edges
module gd_clr_timer #(
  parameter int unsigned CLR_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic clr_ok_o
);
  localparam int unsigned CW = $clog2(CLR_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CLR_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (enable_i)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign clr_ok_o = (cnt_q == LIMIT);
endmodule

// File: rtl/gd_fault_sup.sv
module gd_fault_sup
  import gd_fault_pkg::*;
#(
  parameter int unsigned TRIP_FILT  = 4,
  parameter int unsigned UV_FILT    = 4,
  parameter int unsigned ARM_DLY    = 8,
  parameter int unsigned PHASE_FILT = 4,
  parameter int unsigned CLR_CYC    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic upper_cmd_i,
  input  logic phase_hi_i,
  input  logic uv_low_i,
  input  logic uv_float_i,
  input  logic trip_lo_i,
  input  logic trip_hi_i,
  output logic fault_no,
  output logic fault_o
);
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_q;
  logic               phase_q;
  logic               clr_ok;
  logic               set_any;
  logic               fault_q;

  always_comb begin
    src_raw              = '0;
    src_raw[SRC_UV_LO]   = uv_low_i;
    src_raw[SRC_UV_FL]   = uv_float_i;
    src_raw[SRC_TRIP_LO] = trip_lo_i;
    src_raw[SRC_TRIP_HI] = trip_hi_i;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned FLEN =
      (i == int'(SRC_UV_LO) || i == int'(SRC_UV_FL)) ? UV_FILT : TRIP_FILT;
    gd_persist #(.N(FLEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (src_raw[i]),
      .q_o   (src_q[i])
    );
  end

  gd_phase_chk #(
    .ARM_DLY   (ARM_DLY),
    .PHASE_FILT(PHASE_FILT)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upper_cmd_i(upper_cmd_i),
    .phase_hi_i (phase_hi_i),
    .mismatch_o (phase_q)
  );

  gd_clr_timer #(.CLR_CYC(CLR_CYC)) u_clr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .clr_ok_o(clr_ok)
  );

  assign set_any = (|src_q) | phase_q;

  // set wins over clear, so a persisting cause blocks the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fault_q <= 1'b1;
    else if (set_any) fault_q <= 1'b1;
    else if (clr_ok)  fault_q <= 1'b0;
  end

  assign fault_o  = fault_q;
  assign fault_no = ~fault_q;
endmodule

// File: rtl/gd_fault_sup_chk.sv
module gd_fault_sup_chk
  import gd_fault_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               upper_cmd_i,
  input logic               fault_o,
  input logic               fault_no,
  input logic [NUM_SRC-1:0] src_q,
  input logic               phase_q
);
  // R4 R5 R7
  src_sets_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_q) |=> fault_o);

  // R2 R3
  clr_needs_enable_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(!enable_i));

  // R10
  rise_needs_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past((|src_q) | phase_q));

  // R9
  phase_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upper_cmd_i |=> !phase_q);

  // R8
  phase_sets_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |=> fault_o);

  // R11
  always_comb begin
    if (rst_ni) polarity_chk: assert (fault_no == !fault_o);
  end
endmodule

bind gd_fault_sup gd_fault_sup_chk u_chk (.*);

// File: tb/gd_fault_sup_bench.sv
module gd_fault_sup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TF = 4;
  localparam int UF = 4;
  localparam int AD = 8;
  localparam int PF = 4;
  localparam int CC = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, upper_cmd_i = 1'b0, phase_hi_i = 1'b1;
  logic uv_low_i = 1'b0, uv_float_i = 1'b0, trip_lo_i = 1'b0, trip_hi_i = 1'b0;
  logic fault_no, fault_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    bit    exp_fault;
    string tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gd_fault_sup #(
    .TRIP_FILT(TF), .UV_FILT(UF), .ARM_DLY(AD), .PHASE_FILT(PF), .CLR_CYC(CC)
  ) u_gd_fault_sup (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .upper_cmd_i(upper_cmd_i),
    .phase_hi_i(phase_hi_i), .uv_low_i(uv_low_i), .uv_float_i(uv_float_i),
    .trip_lo_i(trip_lo_i), .trip_hi_i(trip_hi_i), .fault_no(fault_no), .fault_o(fault_o)
  );

  // monitor: compare after each edge that carried an expectation
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (fault_no !== !it.exp_fault) begin
        n_fail++;
        $display("FAIL %s: fault_no=%b expected %b", it.tag, fault_no, !it.exp_fault);
      end
      if (fault_o !== it.exp_fault) begin
        n_fail++;
        $display("FAIL R11 %s: fault_o=%b expected %b", it.tag, fault_o, it.exp_fault);
      end
    end
  end

  task automatic expect_after(input int n, input bit f, input string tag);
    repeat (n) @(posedge clk);
    sb.push_back('{f, tag});
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk) enable_i = 1'b0;
    expect_after(CC + 1, 1'b0, tag);
    @(negedge clk) enable_i = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (fault_no !== 1'b0 || fault_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: fault_no=%b fault_o=%b expected 0 1", fault_no, fault_o);
    end
    rst_ni = 1'b1; // enable_i already low
    expect_after(CC, 1'b1, "R1 held before clear");
    expect_after(1, 1'b0, "R2 clear after window");
    @(negedge clk) enable_i = 1'b1;
    expect_after(4, 1'b0, "R2 stays clear");

    // lower trip with upper off
    @(negedge clk) trip_lo_i = 1'b1;
    expect_after(TF, 1'b0, "R4 not before filter");
    expect_after(1, 1'b1, "R4 lower trip");
    @(negedge clk) trip_lo_i = 1'b0;
    expect_after(6, 1'b1, "R10 latched");
    do_clear("R2 clear after trip");

    // upper trip with upper on
    @(negedge clk) begin upper_cmd_i = 1'b1; trip_hi_i = 1'b1; end
    expect_after(TF, 1'b0, "R5 not before filter");
    expect_after(1, 1'b1, "R5 upper trip");
    @(negedge clk) begin trip_hi_i = 1'b0; upper_cmd_i = 1'b0; end

    // short enable low
    @(negedge clk) enable_i = 1'b0;
    repeat (CC - 1) @(posedge clk);
    @(negedge clk) enable_i = 1'b1;
    expect_after(3, 1'b1, "R3 short enable low");
    do_clear("R2 clear after short try");

    // glitch rejection
    @(negedge clk) trip_lo_i = 1'b1;
    repeat (TF - 1) @(posedge clk);
    @(negedge clk) trip_lo_i = 1'b0;
    expect_after(4, 1'b0, "R6 lower glitch");
    @(negedge clk) begin upper_cmd_i = 1'b1; trip_hi_i = 1'b1; end
    repeat (TF - 1) @(posedge clk);
    @(negedge clk) begin trip_hi_i = 1'b0; upper_cmd_i = 1'b0; end
    expect_after(4, 1'b0, "R6 upper glitch");

    // undervoltage blocks clear
    @(negedge clk) uv_low_i = 1'b1;
    expect_after(UF, 1'b0, "R7 not before filter");
    expect_after(1, 1'b1, "R7 low-side uv");
    @(negedge clk) enable_i = 1'b0;
    expect_after(2 * CC, 1'b1, "R7 uv blocks clear");
    @(negedge clk) uv_low_i = 1'b0;
    expect_after(1, 1'b1, "R7 release first edge");
    expect_after(1, 1'b0, "R7 release clears");
    @(negedge clk) enable_i = 1'b1;
    @(negedge clk) uv_float_i = 1'b1;
    expect_after(UF + 1, 1'b1, "R7 floating uv");
    @(negedge clk) uv_float_i = 1'b0;
    do_clear("R2 clear after floating uv");

    // phase disagreement after arming
    @(negedge clk) begin upper_cmd_i = 1'b1; phase_hi_i = 1'b0; end
    expect_after(AD + PF, 1'b0, "R8 not before arm+filter");
    expect_after(1, 1'b1, "R8 phase mismatch");
    @(negedge clk) begin upper_cmd_i = 1'b0; phase_hi_i = 1'b1; end
    do_clear("R2 clear after phase");

    // phase low only inside arming window
    @(negedge clk) begin upper_cmd_i = 1'b1; phase_hi_i = 1'b0; end
    repeat (AD - 1) @(posedge clk);
    @(negedge clk) phase_hi_i = 1'b1;
    expect_after(AD + PF + 4, 1'b0, "R9 arming window");
    @(negedge clk) begin upper_cmd_i = 1'b0; phase_hi_i = 1'b0; end
    expect_after(AD + PF + 4, 1'b0, "R9 upper off");
    @(negedge clk) phase_hi_i = 1'b1;
    expect_after(2, 1'b0, "R9 idle");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule